// File: doc/BRIEF.md
# I2C Octal DAC Code Register Target

This block is a write-only I2C target that holds eight 8-bit codes for a bank of trim DACs. A bus host sends a transfer in three parts. First comes a device-address byte. Next comes an instruction byte. Any number of data bytes follow. The block oversamples SCL and SDA with the system clock through a synchronizer and detects START and STOP from those samples. It shifts each byte in MSB first and pulls SDA low through an open-drain enable in the acknowledge slot.

The device address is `0100 s2 s1 s0 0`, where the three strap inputs fill bits 3 down to 1. Up to eight devices can therefore share one bus. The high nibble of the instruction byte selects the mode: `0x0` gives an incrementing sub-address and `0xF` gives a fixed one. The low nibble is a 4-bit sub-address, and values 0 to 7 select a code register.

The eight codes leave the block as one flat bus, with channel i at bits `[8*i+7:8*i]`. These codes drive the analog converters directly.

Top module: `trim_dac_i2c_target`

## Requirements
- R1: A write address byte equal to `{4'b0100, strap, 1'b0}` is acknowledged. The instruction byte and the data bytes after it are also acknowledged.
- R2: An address byte that does not match gets no acknowledge. Every later byte up to the next START or STOP gets no acknowledge and changes no code.
- R3: An address byte with bit 0 set (read) is never acknowledged, even when bits 7:1 match.
- R4: When parameter FORCE_A2 is 1, address bit 3 compares against 1 whatever the level on strap bit 2.
- R5: An instruction byte whose high nibble is neither 0x0 nor 0xF is still acknowledged. The data bytes after it are acknowledged and change no code.
- R6: The low nibble of the instruction byte is the sub-address. With sub-address n in 0..7, the first data byte is written into channel n.
- R7: With instruction high nibble 0x0, the sub-address increases by one after every data byte.
- R8: An incrementing sub-address wraps from 0xF to 0x0, so writes resume at channel 0.
- R9: A data byte sent while the sub-address is 8..F is acknowledged and changes no channel.
- R10: With instruction high nibble 0xF, every data byte overwrites the same channel, and the last byte sent remains.
- R11: After reset every code is 0x00 and SDA is not driven. A code changes only in response to a received data byte, and one byte changes at most one code.
- R12: A repeated START makes the next byte an address byte again.
- R13: The SDA pull-down starts only while SCL is low, lasts only for the acknowledge slot, and is released at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| strap_i | input | 3 | Device address straps, bit 2 down to bit 0 |
| dac_codes_o | output | NUM_CH*8 | Eight DAC codes, channel i at bits 8*i+7:8*i |

## Verification
The bench builds two instances with NUM_CH = 8 and SYNC_STAGES = 2. Both instances share the bus lines. One uses FORCE_A2 = 0 with straps 101. The other uses FORCE_A2 = 1 with straps 010, so its strap bit 2 is overridden. This setup covers address matching and the forced strap in the same transfers. With eight channels and a 4-bit sub-address, sub-addresses 8 to F are left unbacked. Incrementing runs therefore reach the unbacked range and then wrap back to channel 0 within a dozen data bytes.

// File: rtl/trim_dac_pkg.sv
package trim_dac_pkg;

  localparam int BYTE_W = 8;
  localparam int SUB_W  = 4;

  localparam logic [3:0] MODE_AUTO  = 4'h0;
  localparam logic [3:0] MODE_FIXED = 4'hF;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ADDR,
    FR_INSTR,
    FR_DATA,
    FR_SKIP
  } frame_st_e;

endpackage

// File: rtl/trim_dac_line_sync.sv
module trim_dac_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  // The bus idles high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe_q[STAGES-1];
  assign sda_q     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev_q;
  assign scl_fall  = ~scl_q & scl_prev_q;
  assign start_det = scl_q & scl_prev_q & sda_prev_q & ~sda_q;
  assign stop_det  = scl_q & scl_prev_q & ~sda_prev_q & sda_q;

endmodule

// File: rtl/trim_dac_byte_rx.sv
module trim_dac_byte_rx
  import trim_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ack_req,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_stb,
  output logic              sda_oe_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              stb_q, stb_d;
  logic              in_ack_q, in_ack_d;
  logic              oe_q, oe_d;
  logic              ack_lat_q, ack_lat_d;

  always_comb begin
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    stb_d     = 1'b0;
    in_ack_d  = in_ack_q;
    oe_d      = oe_q;
    ack_lat_d = ack_lat_q;
    if (start_det || stop_det) begin
      cnt_d    = '0;
      in_ack_d = 1'b0;
      oe_d     = 1'b0;
    end else begin
      if (scl_rise && (cnt_q < ACK_POS)) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_q};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) stb_d = 1'b1;
      end
      if (stb_q) ack_lat_d = ack_req;
      if (scl_fall && (cnt_q == ACK_POS)) begin
        if (!in_ack_q) begin
          in_ack_d = 1'b1;
          oe_d     = ack_lat_q;
        end else begin
          in_ack_d = 1'b0;
          oe_d     = 1'b0;
          cnt_d    = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      stb_q     <= 1'b0;
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
      ack_lat_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      stb_q     <= stb_d;
      in_ack_q  <= in_ack_d;
      oe_q      <= oe_d;
      ack_lat_q <= ack_lat_d;
    end
  end

  assign byte_o   = sh_q;
  assign byte_stb = stb_q;
  assign sda_oe_o = oe_q;

endmodule

// File: rtl/trim_dac_frame_ctl.sv
module trim_dac_frame_ctl
  import trim_dac_pkg::*;
#(
  parameter int         NUM_CH = 8,
  parameter logic [3:0] DEV_HI = 4'h4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic                      byte_stb,
  input  logic [BYTE_W-1:0]         byte_i,
  input  logic [2:0]                strap_eff,
  output logic                      ack_req,
  output logic                      wr_stb,
  output logic [$clog2(NUM_CH)-1:0] wr_idx,
  output logic [BYTE_W-1:0]         wr_data,
  output frame_st_e                 state_o
);

  localparam int IDX_W = $clog2(NUM_CH);
  localparam logic [SUB_W:0] CH_LIMIT = (SUB_W + 1)'(NUM_CH);

  frame_st_e        state_q, state_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             auto_q, auto_d;
  logic             valid_q, valid_d;
  logic             addr_hit;
  logic             sub_backed;

  assign addr_hit   = (byte_i[7:4] == DEV_HI) && (byte_i[3:1] == strap_eff) && !byte_i[0];
  assign sub_backed = ({1'b0, sub_q} < CH_LIMIT);

  always_comb begin
    state_d = state_q;
    sub_d   = sub_q;
    auto_d  = auto_q;
    valid_d = valid_q;
    ack_req = 1'b0;
    wr_stb  = 1'b0;
    if (start_det) begin
      state_d = FR_ADDR;
    end else if (stop_det) begin
      state_d = FR_IDLE;
    end else if (byte_stb) begin
      unique case (state_q)
        FR_ADDR: begin
          if (addr_hit) begin
            ack_req = 1'b1;
            state_d = FR_INSTR;
          end else begin
            state_d = FR_SKIP;
          end
        end
        FR_INSTR: begin
          ack_req = 1'b1;
          sub_d   = byte_i[SUB_W-1:0];
          auto_d  = (byte_i[7:4] == MODE_AUTO);
          valid_d = (byte_i[7:4] == MODE_AUTO) || (byte_i[7:4] == MODE_FIXED);
          state_d = FR_DATA;
        end
        FR_DATA: begin
          ack_req = 1'b1;
          if (valid_q && sub_backed) wr_stb = 1'b1;
          if (valid_q && auto_q) sub_d = sub_q + 1'b1;
        end
        default: begin
          ack_req = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      sub_q   <= '0;
      auto_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      auto_q  <= auto_d;
      valid_q <= valid_d;
    end
  end

  assign wr_idx  = sub_q[IDX_W-1:0];
  assign wr_data = byte_i;
  assign state_o = state_q;

endmodule

// File: rtl/trim_dac_code_bank.sv
module trim_dac_code_bank
  import trim_dac_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_stb,
  input  logic [$clog2(NUM_CH)-1:0] wr_idx,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [NUM_CH*BYTE_W-1:0]  codes_o
);

  localparam int IDX_W = $clog2(NUM_CH);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [BYTE_W-1:0] code_q, code_d;
    logic              hit;

    assign hit = wr_stb && (wr_idx == IDX_W'(ch));

    always_comb begin
      code_d = code_q;
      if (hit) code_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
    end

    assign codes_o[ch*BYTE_W +: BYTE_W] = code_q;
  end

endmodule

// File: rtl/trim_dac_i2c_target.sv
module trim_dac_i2c_target
  import trim_dac_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit FORCE_A2    = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic [2:0]               strap_i,
  output logic [NUM_CH*BYTE_W-1:0] dac_codes_o
);

  localparam int   IDX_W    = $clog2(NUM_CH);
  localparam logic FORCE_HI = FORCE_A2;

  logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_stb, ack_req, wr_stb;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [2:0]        strap_eff;
  frame_st_e         frame_state;

  assign strap_eff = {strap_i[2] | FORCE_HI, strap_i[1:0]};

  trim_dac_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  trim_dac_byte_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_req   (ack_req),
    .byte_o    (rx_byte),
    .byte_stb  (byte_stb),
    .sda_oe_o  (sda_oe_o)
  );

  trim_dac_frame_ctl #(.NUM_CH(NUM_CH)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_stb  (byte_stb),
    .byte_i    (rx_byte),
    .strap_eff (strap_eff),
    .ack_req   (ack_req),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .state_o   (frame_state)
  );

  trim_dac_code_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .codes_o (dac_codes_o)
  );

endmodule

// File: rtl/trim_dac_i2c_target_chk.sv
module trim_dac_i2c_target_chk
  import trim_dac_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_q,
  input logic                     start_det,
  input logic                     stop_det,
  input logic                     byte_stb,
  input frame_st_e                frame_state,
  input logic                     sda_oe_o,
  input logic [NUM_CH*BYTE_W-1:0] dac_codes_o
);

  logic [NUM_CH*BYTE_W-1:0] prev_codes_q;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_codes_q <= '0;
    else        prev_codes_q <= dac_codes_o;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chg
    assign chg[ch] = dac_codes_o[ch*BYTE_W +: BYTE_W] != prev_codes_q[ch*BYTE_W +: BYTE_W];
  end

  // R13
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_q);

  // R13
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe_o);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_state == FR_SKIP) |-> !sda_oe_o);

  // R11
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> $stable(dac_codes_o));

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1);

endmodule

bind trim_dac_i2c_target trim_dac_i2c_target_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_q       (scl_q),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .byte_stb    (byte_stb),
  .frame_state (frame_state),
  .sda_oe_o    (sda_oe_o),
  .dac_codes_o (dac_codes_o)
);

// File: tb/test_trim_dac_i2c_target.sv
module test_trim_dac_i2c_target;

  localparam int NUM_CH = 8;
  localparam int QW     = 4;
  localparam int HW     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        scl, sda;
  logic [2:0]  strap_a, strap_b;
  logic        oe_a, oe_b;
  logic [63:0] codes_a, codes_b;

  trim_dac_i2c_target #(.NUM_CH(NUM_CH), .SYNC_STAGES(2), .FORCE_A2(1'b0)) i_trim_dac_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(oe_a),
    .strap_i(strap_a), .dac_codes_o(codes_a));

  trim_dac_i2c_target #(.NUM_CH(NUM_CH), .SYNC_STAGES(2), .FORCE_A2(1'b1)) i_trim_dac_i2c_target_forced (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(oe_b),
    .strap_i(strap_b), .dac_codes_o(codes_b));

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_code [NUM_CH];
  int         m_phase;
  logic [3:0] m_sub;
  bit         m_auto, m_valid;
  bit         last_ack_b;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i*8 +: 8] = exp_code[i];
    return v;
  endfunction

  // Reference model of one received byte; returns the expected acknowledge.
  function automatic bit model_byte(input logic [7:0] b);
    bit ack;
    ack = 1'b0;
    case (m_phase)
      0: begin
        ack     = (b[7:4] == 4'h4) && (b[3:1] == strap_a) && !b[0];
        m_phase = ack ? 1 : 3;
      end
      1: begin
        ack     = 1'b1;
        m_sub   = b[3:0];
        m_auto  = (b[7:4] == 4'h0);
        m_valid = (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
        m_phase = 2;
      end
      2: begin
        ack = 1'b1;
        if (m_valid && m_sub < 4'd8) exp_code[m_sub[2:0]] = b;
        if (m_valid && m_auto) m_sub = m_sub + 4'd1;
      end
      default: ack = 1'b0;
    endcase
    return ack;
  endfunction

  task automatic bus_start();
    sda = 1'b1; wait_clk(QW);
    scl = 1'b1; wait_clk(HW);
    sda = 1'b0; wait_clk(HW);
    scl = 1'b0; wait_clk(QW);
    m_phase = 0;
  endtask

  task automatic bus_stop();
    sda = 1'b0; wait_clk(QW);
    scl = 1'b1; wait_clk(HW);
    sda = 1'b1; wait_clk(HW);
    m_phase = 3;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit exp_ack;
    bit got;
    exp_ack = model_byte(b);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; wait_clk(QW);
      scl = 1'b1; wait_clk(HW);
      scl = 1'b0; wait_clk(QW);
    end
    sda = 1'b1; wait_clk(QW);
    scl = 1'b1; wait_clk(HW/2);
    got        = oe_a;
    last_ack_b = oe_b;
    wait_clk(HW/2);
    scl = 1'b0; wait_clk(QW);
    chk(got == exp_ack, $sformatf("%s ack of %02h", tag, b), 64'(got), 64'(exp_ack));
  endtask

  task automatic check_codes(input string tag);
    wait_clk(4);
    chk(codes_a == exp_vec(), tag, codes_a, exp_vec());
    chk(oe_a == 1'b0, {tag, " R13 idle release"}, 64'(oe_a), 64'd0);
  endtask

  function automatic logic [7:0] own_addr();
    return {4'h4, strap_a, 1'b0};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] a, ins;
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    strap_a = 3'b101; strap_b = 3'b010;
    for (int i = 0; i < NUM_CH; i++) exp_code[i] = 8'h00;
    m_phase = 3; m_sub = 0; m_auto = 0; m_valid = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R11 reset state
    chk(codes_a == 64'd0, "R11 reset codes", codes_a, 64'd0);
    chk(oe_a == 1'b0, "R11 reset sda release", 64'(oe_a), 64'd0);

    // R1 R6 basic write to channel 3
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'h03, "R1");
    send_byte(8'hA5, "R6"); bus_stop(); check_codes("R6 single write");

    // R7 R9 increment from 5 into unbacked range
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'h05, "R7");
    for (int i = 0; i < 5; i++) send_byte(8'h50 + 8'(i), "R9");
    bus_stop(); check_codes("R7 R9 increment");

    // R8 wrap from E through F to 0 and 1
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'h0E, "R8");
    for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i), "R8");
    bus_stop(); check_codes("R8 wrap");

    // R10 fixed mode overwrites channel 2
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'hF2, "R10");
    send_byte(8'h11, "R10"); send_byte(8'h22, "R10"); send_byte(8'h33, "R10");
    bus_stop(); check_codes("R10 fixed");
    chk(codes_a[23:16] == 8'h33, "R10 last byte kept", 64'(codes_a[23:16]), 64'h33);

    // R9 fixed on unbacked sub-address
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'hFA, "R9");
    send_byte(8'h99, "R9"); bus_stop(); check_codes("R9 unbacked fixed");

    // R5 other instruction acknowledged, data dropped
    bus_start(); send_byte(own_addr(), "R1"); send_byte(8'h53, "R5");
    send_byte(8'h77, "R5"); send_byte(8'h78, "R5"); bus_stop(); check_codes("R5 ignored data");

    // R2 mismatched address
    bus_start(); send_byte(8'h40, "R2"); send_byte(8'h00, "R2"); send_byte(8'hEE, "R2");
    bus_stop(); check_codes("R2 no change");

    // R3 read bit set on own address
    bus_start(); send_byte(own_addr() | 8'h01, "R3"); send_byte(8'h01, "R3");
    bus_stop(); check_codes("R3 no change");

    // R12 repeated start
    bus_start(); send_byte(own_addr(), "R12"); send_byte(8'h01, "R12"); send_byte(8'h1E, "R12");
    bus_start(); send_byte(own_addr(), "R12"); send_byte(8'hF4, "R12"); send_byte(8'h44, "R12");
    bus_stop(); check_codes("R12 repeated start");

    // R4 forced strap bit 2 on second instance (strap 010 -> address 0x4C)
    bus_start(); send_byte(8'h44, "R4 unforced form");
    chk(last_ack_b == 1'b0, "R4 raw strap address not acked", 64'(last_ack_b), 64'd0);
    bus_stop();
    bus_start(); send_byte(8'h4C, "R4");
    chk(last_ack_b == 1'b1, "R4 forced address acked", 64'(last_ack_b), 64'd1);
    send_byte(8'h07, "R4"); send_byte(8'h3C, "R4"); bus_stop();
    wait_clk(4);
    chk(codes_b[63:56] == 8'h3C, "R4 forced instance write", 64'(codes_b[63:56]), 64'h3C);
    check_codes("R4 primary untouched");

    // Constrained random transfers: R1 R2 R3 R5 R7 R8 R9 R10
    for (int t = 0; t < 30; t++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6)      a = own_addr();
      else if (r < 8) a = {4'h4, 3'($urandom), 1'b0};
      else            a = own_addr() | 8'h01;
      r = int'($urandom % 3);
      if (r == 0)      ins = {4'h0, 4'($urandom)};
      else if (r == 1) ins = {4'hF, 4'($urandom)};
      else             ins = 8'($urandom);
      n = int'($urandom % 12);
      bus_start();
      send_byte(a, "R1 random");
      send_byte(ins, "R5 random");
      for (int k = 0; k < n; k++) send_byte(8'($urandom), "R7 random");
      bus_stop();
      check_codes("R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule